// File: doc/BRIEF.md
# Ramp PWM Generator with Cycle-by-Cycle Current Limit

This block produces the power-stage switching waveform of a motor drive from a digital ramp in place of an analog sawtooth. An up-counter climbs from zero to a programmable terminal count and then returns to zero. One pass of the ramp is one carrier period. The gate output is high while the ramp is below a duty command, so on-time grows in proportion to the command. The duty command is taken in only at the end of a ramp, so a period is never cut short or stretched by a mid-period update.

An external current comparator feeds a single trip bit. A trip cuts the drivers in the same cycle, through two kill outputs, one for the high-side drivers and one for the low-side drivers. The cut then holds until the ramp ends. At that end-of-ramp cycle the trip bit is sampled again. If it is clear, the drivers return at the start of the next ramp. If it is still set, they stay off for the whole of the next ramp. A mode input chooses whether a trip cuts both driver groups or only the low-side group. A status output shows whenever the current limit is holding the drivers off. With a 50 MHz clock, a terminal count near 2082 gives a carrier of about 24 kHz. The 12-bit default count width covers the 21 to 27 kHz band.

Top module: `pwm_ilim_top`

## Requirements
- R1: After reset, with the trip input low, pwm_gate, kill_hi, kill_lo and ilim_active are all low.
- R2: The ramp runs 0, 1, …, term_cnt and then returns to 0, so a period lasts term_cnt+1 cycles. The end-of-ramp cycle is any cycle whose count is at or above term_cnt, so lowering term_cnt below the present count restarts the ramp on the next cycle.
- R3: pwm_gate is high while the ramp count is below the latched duty. A latched duty of 0 keeps the gate low for the whole period. A latched duty at or above term_cnt keeps it high for the whole period.
- R4: duty_cmd is captured only in the end-of-ramp cycle and takes effect from the following count-0 cycle. Its value in any other cycle has no effect on pwm_gate.
- R5: In any cycle where ilim_trip is high, kill_lo is high in that same cycle, with no register in the path.
- R6: A trip outside the end-of-ramp cycle holds kill_lo high through the end-of-ramp cycle. In the end-of-ramp cycle, ilim_trip is sampled: if low, the hold clears from the next cycle; if high, kill_lo stays high for the entire next ramp.
- R7: With lo_only high, kill_hi stays low whatever the trip state. With lo_only low, kill_hi equals kill_lo.
- R8: ilim_active equals kill_lo in every cycle.
- R9: pwm_gate follows the ramp comparison only and is not masked by the current limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| duty_cmd | input | CNT_W | Duty command, loaded at end of ramp |
| term_cnt | input | CNT_W | Ramp terminal count; period is term_cnt+1 cycles |
| ilim_trip | input | 1 | Overcurrent comparator result, high = over limit |
| lo_only | input | 1 | 1 = trip cuts only low-side drivers, 0 = cuts both groups |
| pwm_gate | output | 1 | PWM gate from ramp versus duty comparison |
| kill_hi | output | 1 | High-side driver cut |
| kill_lo | output | 1 | Low-side driver cut |
| ilim_active | output | 1 | Current limit holding the drivers off |

## Verification
The assertions check the following on every cycle: the ramp's step-or-restart rule, the same-cycle response to a trip, hold until end of ramp, the resample decision at the end-of-ramp cycle, the high-side mode rule and the status output. Duty proportionality and the 0% and 100% ends can be seen only in the bench scenarios, because the latched duty is not visible on any port. The same is true of duty capture at the ramp boundary, of ignoring mid-period duty changes, and of the restart after the terminal count is lowered. The bench compares every cycle against a cycle model over directed corners and a long random run with changing periods, duties and trip pulses.

// File: rtl/pwm_ilim_pkg.sv
package pwm_ilim_pkg;
  // driver cut pair produced by the current-limit stage
  typedef struct packed {
    logic hi;
    logic lo;
  } drv_cut_t;

  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = pwm_ilim_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] term_cnt,
  output logic [CNT_W-1:0] cnt,
  output logic             ramp_end
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // end of ramp also covers a count left above a lowered terminal value
  assign ramp_end = (cnt_q >= term_cnt);
  assign cnt_en   = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (ramp_end) cnt_d = '0;
      else          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ramp_end,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] term_cnt,
  output logic             gate
);
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_d;
  logic             below;
  logic             full_on;

  always_comb begin
    duty_d = duty_q;
    if (ramp_end) duty_d = duty_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  always_comb begin
    below   = (cnt < duty_q);
    full_on = (duty_q >= term_cnt);
    gate    = below | full_on;
  end
endmodule

// File: rtl/pwm_oc_latch.sv
module pwm_oc_latch
  import pwm_ilim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ramp_end,
  input  logic     trip,
  input  logic     lo_only,
  output drv_cut_t cut,
  output logic     active
);
  logic hold_q;
  logic hold_d;
  logic off;

  always_comb begin
    if (ramp_end) hold_d = trip;            // resample at ramp boundary
    else          hold_d = hold_q | trip;   // otherwise accumulate
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    off    = trip | hold_q;
    cut.lo = off;
    cut.hi = off & ~lo_only;
    active = off;
  end
endmodule

// File: rtl/pwm_ilim_top.sv
module pwm_ilim_top
  import pwm_ilim_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] term_cnt,
  input  logic             ilim_trip,
  input  logic             lo_only,
  output logic             pwm_gate,
  output logic             kill_hi,
  output logic             kill_lo,
  output logic             ilim_active
);
  logic             srst_n;
  logic [CNT_W-1:0] cnt;
  logic             ramp_end;
  drv_cut_t         cut;

  pwm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk      (clk),
    .rst_n    (srst_n),
    .term_cnt (term_cnt),
    .cnt      (cnt),
    .ramp_end (ramp_end)
  );

  pwm_duty_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (srst_n),
    .ramp_end (ramp_end),
    .duty_cmd (duty_cmd),
    .cnt      (cnt),
    .term_cnt (term_cnt),
    .gate     (pwm_gate)
  );

  pwm_oc_latch u_oc (
    .clk      (clk),
    .rst_n    (srst_n),
    .ramp_end (ramp_end),
    .trip     (ilim_trip),
    .lo_only  (lo_only),
    .cut      (cut),
    .active   (ilim_active)
  );

  assign kill_hi = cut.hi;
  assign kill_lo = cut.lo;
endmodule

// File: rtl/pwm_ilim_chk.sv
module pwm_ilim_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             srst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             ramp_end,
  input logic             ilim_trip,
  input logic             lo_only,
  input logic             kill_hi,
  input logic             kill_lo,
  input logic             ilim_active
);
  // R2: ramp restarts after its end cycle
  a_r2_restart: assert property (@(posedge clk) disable iff (!srst_n)
    ramp_end |=> (cnt == '0));
  // R2: otherwise it steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!srst_n)
    !ramp_end |=> (cnt == $past(cnt) + 1'b1));
  // R5: same-cycle cut
  a_r5_trip_cuts: assert property (@(posedge clk) disable iff (!srst_n)
    ilim_trip |-> kill_lo);
  // R6: hold until end of ramp
  a_r6_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (kill_lo && !ramp_end) |=> kill_lo);
  // R6: persisting trip at the boundary holds the next ramp
  a_r6_persist: assert property (@(posedge clk) disable iff (!srst_n)
    (ramp_end && ilim_trip) |=> kill_lo);
  // R6: cleared trip at the boundary releases
  a_r6_release: assert property (@(posedge clk) disable iff (!srst_n)
    (ramp_end && !ilim_trip) |=> (kill_lo == ilim_trip));
  // R7: low-side-only mode spares the high side
  a_r7_hi_spared: assert property (@(posedge clk) disable iff (!srst_n)
    lo_only |-> !kill_hi);
  // R7: full mode cuts both together
  a_r7_hi_follows: assert property (@(posedge clk) disable iff (!srst_n)
    !lo_only |-> (kill_hi == kill_lo));
  // R8: status mirrors the cut
  a_r8_status: assert property (@(posedge clk) disable iff (!srst_n)
    ilim_active == kill_lo);
endmodule

bind pwm_ilim_top pwm_ilim_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .cnt         (cnt),
  .ramp_end    (ramp_end),
  .ilim_trip   (ilim_trip),
  .lo_only     (lo_only),
  .kill_hi     (kill_hi),
  .kill_lo     (kill_lo),
  .ilim_active (ilim_active)
);

// File: tb/pwm_ilim_top_test.sv
module pwm_ilim_top_test;
  localparam int W = 12;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] duty_cmd;
  logic [W-1:0] term_cnt;
  logic         ilim_trip;
  logic         lo_only;
  logic         pwm_gate, kill_hi, kill_lo, ilim_active;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  int m_cnt, m_duty;
  bit m_hold;

  pwm_ilim_top #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .term_cnt(term_cnt),
    .ilim_trip(ilim_trip), .lo_only(lo_only), .pwm_gate(pwm_gate),
    .kill_hi(kill_hi), .kill_lo(kill_lo), .ilim_active(ilim_active)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] expect_out(int cnt, int duty, bit hold,
                                            int tc, bit trip, bit lo);
    bit g, off;
    g   = (cnt < duty) || (duty >= tc);
    off = trip || hold;
    return {g, off && !lo, off, off};
  endfunction

  task automatic step(input int d, input int tc, input bit trip,
                      input bit lo, input string tag);
    logic [3:0] exp_v, act_v;
    bit wrap;
    @(negedge clk);
    duty_cmd  = d[W-1:0];
    term_cnt  = tc[W-1:0];
    ilim_trip = trip;
    lo_only   = lo;
    #2;
    exp_v = expect_out(m_cnt, m_duty, m_hold, tc, trip, lo);
    act_v = {pwm_gate, kill_hi, kill_lo, ilim_active};
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: gate/hi/lo/act actual=%b expected=%b (t=%0t)",
               tag, act_v, exp_v, $time);
    end
    wrap   = (m_cnt >= tc);
    m_hold = wrap ? trip : (m_hold || trip);
    if (wrap) m_duty = d;
    m_cnt  = wrap ? 0 : m_cnt + 1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int tc, d;
    bit trip, lo;
    seed = $urandom(32'd2718);
    rst_n = 1'b0; duty_cmd = '0; term_cnt = 12'd7; ilim_trip = 1'b0; lo_only = 1'b0;
    m_cnt = 0; m_duty = 0; m_hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);  // synchronised release

    // R1: reset state
    for (int i = 0; i < 4; i++) step(0, 7, 0, 0, "R1");
    // R3: duty proportional, then 0% and 100% ends
    for (int i = 0; i < 24; i++) step(3, 7, 0, 0, "R3");
    for (int i = 0; i < 20; i++) step(0, 7, 0, 0, "R3 zero");
    for (int i = 0; i < 20; i++) step(7, 7, 0, 0, "R3 full at tc");
    for (int i = 0; i < 20; i++) step(9, 7, 0, 0, "R3 full above tc");
    // R4: duty changes every cycle, only boundary value counts
    for (int i = 0; i < 40; i++) step(i % 9, 7, 0, 0, "R4");
    // R2: lower terminal count below present count
    for (int i = 0; i < 10; i++) step(5, 15, 0, 0, "R2");
    for (int i = 0; i < 12; i++) step(1, 2, 0, 0, "R2 lowered");
    // R5/R6: single trip pulse mid-ramp, full cut mode
    for (int i = 0; i < 20; i++) step(4, 9, (i == 3), 0, "R6 pulse");
    // R6: trip held across the boundary
    for (int i = 0; i < 30; i++) step(4, 9, (i >= 2 && i < 15), 0, "R6 persist");
    // R7: low-side-only mode
    for (int i = 0; i < 30; i++) step(4, 9, (i >= 5 && i < 9), 1, "R7");
    // R9: gate unaffected while tripped
    for (int i = 0; i < 12; i++) step(5, 9, 1, 0, "R9");
    for (int i = 0; i < 12; i++) step(5, 9, 0, 0, "R9");

    // random mix
    tc = 5; lo = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 2) tc = $urandom_range(0, 20);
      if ($urandom_range(0, 99) < 1) lo = ~lo;
      d    = $urandom_range(0, tc + 2);
      trip = ($urandom_range(0, 99) < 6);
      step(d, tc, trip, lo, "R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule